// File: doc/BRIEF.md
# I2S Audio Transceiver

The block is a bus master for a stereo I2S link. It drives the bit clock and the word-select line itself, sends stereo sample pairs taken from a four-entry output queue on the serial data-out pin, and assembles the serial data-in pin into stereo pairs. Those pairs go into a four-entry input queue. Register-side logic writes pairs into the output queue and reads pairs from the input queue through plain push and pop strobes. Each queue position holds a left and a right sample of up to 24 bits.

The register side selects the sample length (16 or 24 bits), whether a slot sends its most or its least significant bit first, and the bit clock polarity at the pin. Each queue has a level interrupt with a selectable condition and a DMA request line. An output queue that runs dry sends silence. An input queue that overflows discards the incoming frame. Each of these events raises a one-cycle pulse.

Top module: `i2s_xcvr`

## Requirements
- R1: Each queue holds exactly 4 stereo pairs. A push to a full output queue is ignored, and `tx_full_o` is high exactly when 4 pairs are held.
- R2: A frame is 64 bit clocks: a 32-clock left slot with `ws_o` low and a 32-clock right slot with `ws_o` high. `ws_o` changes one bit clock before the first bit of a slot. `ws_o` and `sd_o` change only on the launch edge, where `sck_o` moves to the level of `sck_inv_i`. Data is sampled on the opposite edge.
- R3: `sck_o` is the internal bit clock XOR `sck_inv_i`, so during reset `sck_o` equals `sck_inv_i`.
- R4: `res24_i`=1 selects 24-bit samples and 0 selects 16-bit samples. A sample occupies bits [R-1:0] of its 24-bit field. Slot bits R..31 are sent as zero and are ignored on receive, so received upper bits read as zero.
- R5: With `lsb_first_i`=0 a slot sends bit R-1 first. With `lsb_first_i`=1 it sends bit 0 first.
- R6: `tx_irq_o` depends on `tx_irq_sel_i`: 0 when at most 2 pairs are held, 1 when the queue is empty, 2 when at least one position is free, 3 never.
- R7: `rx_irq_o` means the input queue is full when `rx_irq_sel_i`=0, and means it holds at least one pair when `rx_irq_sel_i`=1.
- R8: `tx_dreq_o` is high while the output queue is not full. `rx_dreq_o` is high while the input queue is not empty.
- R9: If the output queue is empty at the start of a frame, the frame carries all-zero data and `tx_underrun_o` pulses for one cycle.
- R10: If the input queue is full when a frame completes, the frame is dropped, `rx_overrun_o` pulses, and the 4 held pairs are kept.
- R11: With `sd_o` looped back to `sd_i`, pairs come out of the input queue in the order they were pushed, masked to R bits.
- R12: During reset both queues are empty, `ws_o` and `sd_o` are low, and no interrupt other than the output-queue level condition is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res24_i | input | 1 | 1: 24-bit samples, 0: 16-bit samples |
| lsb_first_i | input | 1 | 1: least significant bit first |
| sck_inv_i | input | 1 | Inverts the bit clock at the pin |
| tx_irq_sel_i | input | 2 | Output queue interrupt condition |
| rx_irq_sel_i | input | 1 | Input queue interrupt condition |
| tx_push_i | input | 1 | Writes one pair into the output queue |
| tx_left_i | input | 24 | Left sample to write |
| tx_right_i | input | 24 | Right sample to write |
| tx_full_o | output | 1 | Output queue full |
| rx_pop_i | input | 1 | Removes the head pair of the input queue |
| rx_left_o | output | 24 | Head left sample of the input queue |
| rx_right_o | output | 24 | Head right sample of the input queue |
| rx_empty_o | output | 1 | Input queue empty |
| tx_irq_o | output | 1 | Output queue level interrupt |
| rx_irq_o | output | 1 | Input queue level interrupt |
| tx_dreq_o | output | 1 | DMA request, output direction |
| rx_dreq_o | output | 1 | DMA request, input direction |
| tx_underrun_o | output | 1 | Pulse: a frame was sent from an empty queue |
| rx_overrun_o | output | 1 | Pulse: a received frame was dropped |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |

## Verification
A wrong frame position counter shows on the wire within one frame. The word-select edges no longer fall on 32-clock boundaries, and a decoder on `sck_o`, `ws_o` and `sd_o` sees slots of the wrong length. A wrong bit-index selection under any sample length or shift direction also shows on the wire within one frame, as wrong sample values or as non-zero pad bits. A queue pointer or count error shows within a few frames. Pairs come back out of order or missing, or the number of pairs read after an overflow differs from four. An error in the level-interrupt or DMA decode shows in the same cycle as the push or pop that moves the count.

// File: rtl/i2s_pkg.sv
`timescale 1ns/1ps
package i2s_pkg;
  localparam int unsigned SMP_W = 24;
  localparam int unsigned IDX_W = $clog2(SMP_W);

  typedef struct packed {
    logic [SMP_W-1:0] left;
    logic [SMP_W-1:0] right;
  } stereo_t;

  typedef enum logic [1:0] {
    TXI_HALF     = 2'd0,
    TXI_EMPTY    = 2'd1,
    TXI_ONE_FREE = 2'd2,
    TXI_OFF      = 2'd3
  } tx_irq_sel_e;

  // position of slot bit k inside the sample field
  function automatic logic [IDX_W-1:0] bit_index(logic [IDX_W-1:0] k, logic res24, logic lsb_first);
    logic [IDX_W-1:0] r;
    r = res24 ? IDX_W'(24) : IDX_W'(16);
    return lsb_first ? k : (r - IDX_W'(1) - k);
  endfunction
endpackage

// File: rtl/i2s_fifo.sv
`timescale 1ns/1ps
module i2s_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 48,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r1_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  a_r1_full_push_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o && $stable(wr_q));
endmodule

// File: rtl/i2s_clkgen.sv
`timescale 1ns/1ps
module i2s_clkgen #(
  parameter int unsigned CLK_DIV = 2,
  parameter int unsigned SLOT_W  = 32,
  localparam int unsigned FW     = $clog2(2 * SLOT_W),
  localparam int unsigned DW     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          launch_o,
  output logic          capture_o,
  output logic [FW-1:0] bc_o,
  output logic          sck_raw_o,
  output logic          ws_o
);
  logic [DW-1:0] div_q;
  logic [FW-1:0] bc_q, bc_nxt;
  logic          sck_q, ws_q, tick;

  assign tick      = (div_q == DW'(CLK_DIV - 1));
  assign launch_o  = tick && sck_q;
  assign capture_o = tick && !sck_q;
  assign bc_nxt    = bc_q + FW'(1);
  assign bc_o      = bc_q;
  assign sck_raw_o = sck_q;
  assign ws_o      = ws_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sck_q <= 1'b0;
      bc_q  <= '0;
      ws_q  <= 1'b0;
    end else begin
      div_q <= tick ? '0 : div_q + DW'(1);
      if (tick) sck_q <= ~sck_q;
      if (launch_o) begin
        bc_q <= bc_nxt;
        ws_q <= bc_nxt[FW-1];  // flips one bit before the slot's first bit
      end
    end
  end

  a_r2_ws_on_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_o) |-> $past(launch_o));
  a_r2_ws_with_falling_sck: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_o) |-> $fell(sck_raw_o));
endmodule

// File: rtl/i2s_tx_ser.sv
`timescale 1ns/1ps
module i2s_tx_ser import i2s_pkg::*; #(
  parameter int unsigned SLOT_W = 32,
  localparam int unsigned FW    = $clog2(2 * SLOT_W),
  localparam int unsigned KW    = FW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic [FW-1:0] bc_i,
  input  stereo_t       fifo_data_i,
  input  logic          fifo_empty_i,
  input  logic          res24_i,
  input  logic          lsb_first_i,
  output logic          fifo_pop_o,
  output logic          sd_o,
  output logic          underrun_o
);
  stereo_t          cur_q;
  logic [SMP_W-1:0] smp;
  logic [KW-1:0]    k;
  logic             chan, frame_start, nxt_bit, sd_q, und_q;

  // bit launched now belongs to position bc_i
  always_comb begin
    chan        = bc_i[FW-1];
    k           = bc_i[KW-1:0];
    frame_start = (bc_i == '0);
    if (frame_start) smp = fifo_empty_i ? '0 : fifo_data_i.left;
    else             smp = chan ? cur_q.right : cur_q.left;
    if (k < KW'(res24_i ? 24 : 16)) nxt_bit = smp[bit_index(IDX_W'(k), res24_i, lsb_first_i)];
    else                            nxt_bit = 1'b0;
  end

  assign fifo_pop_o = launch_i && frame_start && !fifo_empty_i;
  assign sd_o       = sd_q;
  assign underrun_o = und_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      sd_q  <= 1'b0;
      und_q <= 1'b0;
    end else begin
      und_q <= 1'b0;
      if (launch_i) begin
        sd_q <= nxt_bit;
        if (frame_start) begin
          cur_q <= fifo_empty_i ? '0 : fifo_data_i;
          und_q <= fifo_empty_i;
        end
      end
    end
  end

  a_r2_sd_on_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> $past(launch_i));
  a_r9_underrun_sends_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> !sd_o);
endmodule

// File: rtl/i2s_rx_des.sv
`timescale 1ns/1ps
module i2s_rx_des import i2s_pkg::*; #(
  parameter int unsigned SLOT_W = 32,
  localparam int unsigned FW    = $clog2(2 * SLOT_W),
  localparam int unsigned KW    = FW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [FW-1:0] bc_i,
  input  logic          sd_i,
  input  logic          res24_i,
  input  logic          lsb_first_i,
  input  logic          fifo_full_i,
  output logic          push_o,
  output stereo_t       pair_o,
  output logic          overrun_o
);
  logic [SMP_W-1:0] l_q, r_q;
  logic [FW-1:0]    pos;
  logic [KW-1:0]    k;
  logic [IDX_W-1:0] idx;
  logic             chan, in_rng, armed_q, push_q, ovr_q;

  // bit sampled now was launched at position bc_i - 1
  always_comb begin
    pos    = bc_i - FW'(1);
    chan   = pos[FW-1];
    k      = pos[KW-1:0];
    in_rng = (k < KW'(res24_i ? 24 : 16));
    idx    = bit_index(IDX_W'(k), res24_i, lsb_first_i);
  end

  assign pair_o    = {l_q, r_q};
  assign push_o    = push_q;
  assign overrun_o = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_q     <= '0;
      r_q     <= '0;
      armed_q <= 1'b0;
      push_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      push_q <= 1'b0;
      ovr_q  <= 1'b0;
      if (capture_i) begin
        if (!chan) begin
          if (k == '0) begin
            l_q     <= '0;
            armed_q <= 1'b1;
          end
          if (in_rng) l_q[idx] <= sd_i;
        end else begin
          if (k == '0) r_q <= '0;
          if (in_rng) r_q[idx] <= sd_i;
        end
        if (pos == '1 && armed_q) begin
          if (fifo_full_i) ovr_q  <= 1'b1;
          else             push_q <= 1'b1;
        end
      end
    end
  end

  a_r10_no_push_with_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_o && overrun_o));
endmodule

// File: rtl/i2s_xcvr.sv
`timescale 1ns/1ps
module i2s_xcvr import i2s_pkg::*; #(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned SLOT_W     = 32,
  parameter int unsigned CLK_DIV    = 2,
  localparam int unsigned FW        = $clog2(2 * SLOT_W),
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res24_i,
  input  logic             lsb_first_i,
  input  logic             sck_inv_i,
  input  logic [1:0]       tx_irq_sel_i,
  input  logic             rx_irq_sel_i,
  input  logic             tx_push_i,
  input  logic [SMP_W-1:0] tx_left_i,
  input  logic [SMP_W-1:0] tx_right_i,
  output logic             tx_full_o,
  input  logic             rx_pop_i,
  output logic [SMP_W-1:0] rx_left_o,
  output logic [SMP_W-1:0] rx_right_o,
  output logic             rx_empty_o,
  output logic             tx_irq_o,
  output logic             rx_irq_o,
  output logic             tx_dreq_o,
  output logic             rx_dreq_o,
  output logic             tx_underrun_o,
  output logic             rx_overrun_o,
  output logic             sck_o,
  output logic             ws_o,
  output logic             sd_o,
  input  logic             sd_i
);
  logic          launch, capture, sck_raw;
  logic [FW-1:0] bc;
  stereo_t       tx_head, rx_pair, rx_head;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_empty, tx_pop, rx_push, rx_full;
  tx_irq_sel_e   tx_sel;

  i2s_clkgen #(.CLK_DIV(CLK_DIV), .SLOT_W(SLOT_W)) u_clkgen (
    .clk_i, .rst_ni,
    .launch_o(launch), .capture_o(capture), .bc_o(bc),
    .sck_raw_o(sck_raw), .ws_o(ws_o)
  );

  i2s_fifo #(.DEPTH(FIFO_DEPTH), .W(2 * SMP_W)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push_i), .wdata_i({tx_left_i, tx_right_i}),
    .pop_i(tx_pop), .rdata_o(tx_head),
    .count_o(tx_cnt), .full_o(tx_full_o), .empty_o(tx_empty)
  );

  i2s_tx_ser #(.SLOT_W(SLOT_W)) u_tx_ser (
    .clk_i, .rst_ni,
    .launch_i(launch), .bc_i(bc),
    .fifo_data_i(tx_head), .fifo_empty_i(tx_empty),
    .res24_i, .lsb_first_i,
    .fifo_pop_o(tx_pop), .sd_o(sd_o), .underrun_o(tx_underrun_o)
  );

  i2s_rx_des #(.SLOT_W(SLOT_W)) u_rx_des (
    .clk_i, .rst_ni,
    .capture_i(capture), .bc_i(bc), .sd_i,
    .res24_i, .lsb_first_i,
    .fifo_full_i(rx_full),
    .push_o(rx_push), .pair_o(rx_pair), .overrun_o(rx_overrun_o)
  );

  i2s_fifo #(.DEPTH(FIFO_DEPTH), .W(2 * SMP_W)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .wdata_i(rx_pair),
    .pop_i(rx_pop_i), .rdata_o(rx_head),
    .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty_o)
  );

  assign rx_left_o  = rx_head.left;
  assign rx_right_o = rx_head.right;
  assign sck_o      = sck_raw ^ sck_inv_i;
  assign tx_dreq_o  = !tx_full_o;
  assign rx_dreq_o  = !rx_empty_o;

  always_comb begin
    tx_sel = tx_irq_sel_e'(tx_irq_sel_i);
    case (tx_sel)
      TXI_HALF:     tx_irq_o = (tx_cnt <= CW'(FIFO_DEPTH / 2));
      TXI_EMPTY:    tx_irq_o = tx_empty;
      TXI_ONE_FREE: tx_irq_o = !tx_full_o;
      default:      tx_irq_o = 1'b0;
    endcase
    rx_irq_o = rx_irq_sel_i ? !rx_empty_o : rx_full;
  end

  a_r10_overrun_only_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_overrun_o |-> $past(rx_full));
  a_r10_overrun_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_overrun_o && !rx_pop_i |=> rx_cnt == CW'(FIFO_DEPTH));
  a_r9_underrun_at_frame_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_underrun_o |-> $past(tx_empty) && $past(launch) && $past(bc) == '0);
endmodule

// File: tb/i2s_xcvr_bench.sv
`timescale 1ns/1ps
module i2s_xcvr_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic res24 = 1'b0, lsb = 1'b0, inv = 1'b0;
  logic [1:0] tx_sel = 2'd0;
  logic rx_sel = 1'b0, tx_push = 1'b0, rx_pop = 1'b0;
  logic [23:0] tx_l = '0, tx_r = '0;
  logic tx_full, rx_empty, tx_irq, rx_irq, tx_dreq, rx_dreq, und, ovr, sck, ws, sd;
  logic [23:0] rx_l, rx_r;

  i2s_xcvr u_i2s_xcvr (
    .clk_i(clk), .rst_ni(rst_n), .res24_i(res24), .lsb_first_i(lsb), .sck_inv_i(inv),
    .tx_irq_sel_i(tx_sel), .rx_irq_sel_i(rx_sel),
    .tx_push_i(tx_push), .tx_left_i(tx_l), .tx_right_i(tx_r), .tx_full_o(tx_full),
    .rx_pop_i(rx_pop), .rx_left_o(rx_l), .rx_right_o(rx_r), .rx_empty_o(rx_empty),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq), .tx_dreq_o(tx_dreq), .rx_dreq_o(rx_dreq),
    .tx_underrun_o(und), .rx_overrun_o(ovr),
    .sck_o(sck), .ws_o(ws), .sd_o(sd), .sd_i(sd)
  );

  int total = 0, bad = 0;
  int und_cnt = 0, ovr_cnt = 0, wire_k = 0;
  logic [23:0] el [5];
  logic [23:0] er [5];
  logic [23:0] mask;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (und) und_cnt++;
    if (ovr) ovr_cnt++;
  end

  // independent wire decoder
  logic sck_p, ws_p, ws_c;
  logic [63:0] bits_c, bits_l;
  int cnt_c = 0, cnt_l = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      sck_p = inv; ws_p = 1'b0; ws_c = 1'b0; cnt_c = 0; wire_k = 0; bits_c = '0;
    end else begin
      if (ws != ws_p) chk(sck == inv, "R2 ws moves on launch edge", {31'b0, sck}, {31'b0, inv});
      ws_p = ws;
      if (sck != sck_p && sck == !inv) begin
        if (cnt_c < 64) bits_c[cnt_c] = sd;
        cnt_c++;
        if (ws != ws_c) begin
          if (!ws_c) begin
            bits_l = bits_c; cnt_l = cnt_c;
          end else begin
            logic [23:0] vl, vr;
            bit pad_bad;
            int r;
            r = res24 ? 24 : 16;
            vl = '0; vr = '0; pad_bad = 0;
            for (int j = 0; j < 32; j++) begin
              if (j < r) begin
                if (lsb) begin vl[j] = bits_l[j]; vr[j] = bits_c[j]; end
                else begin vl[r-1-j] = bits_l[j]; vr[r-1-j] = bits_c[j]; end
              end else if (bits_l[j] || bits_c[j]) pad_bad = 1;
            end
            if ((vl | vr) != 0 || pad_bad) begin
              chk(cnt_l == 32 && cnt_c == 32, "R2 slot length 32", cnt_l, 32);
              chk(!pad_bad, "R4 pad bits zero on wire", {31'b0, pad_bad}, 0);
              if (wire_k < 4) begin
                chk(vl == (el[wire_k] & mask), "R5 wire left sample", vl, el[wire_k] & mask);
                chk(vr == (er[wire_k] & mask), "R5 wire right sample", vr, er[wire_k] & mask);
              end
              wire_k++;
            end
          end
          cnt_c = 0;
          bits_c = '0;
        end
        ws_c = ws;
      end
      sck_p = sck;
    end
  end

  task automatic wait_ws_rise();
    logic p;
    do begin
      p = ws;
      @(negedge clk);
    end while (!(!p && ws));
  endtask

  task automatic push(input int i);
    tx_l = el[i]; tx_r = er[i]; tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic pop();
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 8; c++) begin
      int got, n;
      bit irq_seen;
      res24 = c[0]; lsb = c[1]; inv = c[2];
      mask = res24 ? 24'hFFFFFF : 24'h00FFFF;
      for (int i = 0; i < 5; i++) begin
        el[i] = 24'(32'hC30001 + i * 32'h010203 + c * 32'h101010);
        er[i] = 24'(32'hC30001 + i * 32'h010203 + 32'h0A0B0C + c * 32'h101010);
      end
      tx_sel = 2'd0; rx_sel = 1'b0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(sck == inv, "R3 idle sck level", {31'b0, sck}, {31'b0, inv});
      chk(!ws && !sd, "R12 ws and sd low", {30'b0, ws, sd}, 0);
      chk(rx_empty && !tx_full && tx_dreq && !rx_dreq, "R12 queues empty",
          {28'b0, rx_empty, tx_full, tx_dreq, rx_dreq}, 32'b1010);
      chk(tx_irq && !rx_irq, "R12 irq state", {30'b0, tx_irq, rx_irq}, 32'b10);
      und_cnt = 0; ovr_cnt = 0;
      rst_n = 1'b1;
      wait_ws_rise();
      wait_ws_rise();
      chk(und_cnt > 0, "R9 underrun pulse", und_cnt, 1);
      while (!rx_empty) begin
        chk(rx_l == 0 && rx_r == 0, "R9 silent frame", {8'b0, rx_l}, 0);
        pop();
      end
      for (int lv = 0; lv <= 4; lv++) begin
        for (int s = 0; s < 4; s++) begin
          bit e;
          tx_sel = 2'(s);
          #1;
          e = (s == 0) ? (lv <= 2) : (s == 1) ? (lv == 0) : (s == 2) ? (lv < 4) : 1'b0;
          chk(tx_irq == e, "R6 tx irq condition", {31'b0, tx_irq}, {31'b0, e});
        end
        chk(tx_dreq == (lv < 4), "R8 tx dma request", {31'b0, tx_dreq}, {31'b0, lv < 4});
        chk(tx_full == (lv == 4), "R1 tx full flag", {31'b0, tx_full}, {31'b0, lv == 4});
        @(negedge clk);
        if (lv < 4) push(lv);
      end
      push(4);  // queue full: must vanish
      got = 0; irq_seen = 0;
      for (int f = 0; f < 7; f++) begin
        wait_ws_rise();
        if (!rx_empty && !irq_seen) begin
          irq_seen = 1;
          rx_sel = 1'b1; #1;
          chk(rx_irq, "R7 rx irq one entry", {31'b0, rx_irq}, 1);
          rx_sel = 1'b0; #1;
          chk(!rx_irq, "R7 rx irq not full", {31'b0, rx_irq}, 0);
          chk(rx_dreq, "R8 rx dma request", {31'b0, rx_dreq}, 1);
          @(negedge clk);
        end
        while (!rx_empty) begin
          if (rx_l != 0 || rx_r != 0) begin
            if (got < 4) begin
              chk(rx_l == (el[got] & mask), "R11 loopback left", rx_l, el[got] & mask);
              chk(rx_r == (er[got] & mask), "R4 loopback right masked", rx_r, er[got] & mask);
            end
            got++;
          end
          pop();
        end
      end
      chk(got == 4, "R11 four pairs returned", got, 4);
      chk(wire_k == 4, "R1 push to full queue ignored", wire_k, 4);
      ovr_cnt = 0;
      repeat (6) wait_ws_rise();
      rx_sel = 1'b0; #1;
      chk(rx_irq, "R7 rx irq full", {31'b0, rx_irq}, 1);
      chk(ovr_cnt > 0, "R10 overrun pulse", ovr_cnt, 1);
      @(negedge clk);
      n = 0;
      while (!rx_empty && n < 10) begin
        pop();
        n++;
      end
      chk(n == 4, "R10 held pairs kept", n, 4);
      chk(!rx_dreq, "R8 rx dma idle", {31'b0, rx_dreq}, 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule